// File: doc/BRIEF.md
# Renaming Completion Buffer

The block is a register store that acts as the rename map and the register file at once. It maps a set of logical general registers onto a larger pool of physical slots. Each slot records which logical register it stands for, whether that register is privileged, whether the slot is the newest mapping for that register, whether its value has arrived, and the value itself. A result is written straight into its slot and stays there as the architectural value. It is never copied to a separate file.

The block has four ports. The allocate port is valid/ready. When `alloc_valid` and `alloc_ready` are both high at a clock edge, the slot shown on `alloc_pidx` in that cycle is taken. `alloc_ready` is low only when no slot is free. A request held while `alloc_ready` is low has no effect, and the requester must keep it until ready returns. The writeback, release and lookup ports have no back-pressure: every valid beat is taken at the edge it is presented.

A lookup searches associatively for the newest slot of a logical register. The search uses the current mode. In user mode, privileged slots are excluded. Comparators for slots that are not eligible are gated off. The value array is read only for a ready match. A lookup sees the state as it was before any allocate, writeback or release in the same cycle.

Top module: `cbuf_rename_top`

## Requirements
- R1: After reset, slots 0 to 31 hold logical registers 0 to 31 (slot i holds register i), ready and zero-valued. Slots 32 to 63 are free, `alloc_ready` is 1, and `lk_hit`, `lk_rdy`, `lk_pidx` and `lk_data` are 0.
- R2: `alloc_pidx` shows the lowest-numbered free slot in the same cycle. An accepted allocation makes that slot the newest mapping of `alloc_lreg`, with ready cleared.
- R3: An accepted allocation clears the newest flag of the slot that previously mapped the same logical register, so later lookups return the new slot.
- R4: A writeback to a slot index stores `wb_data` and sets that slot ready, in any order with respect to allocation.
- R5: A lookup presented with `lk_valid` updates `lk_hit`, `lk_pidx` and `lk_rdy` one clock later. On a miss, `lk_pidx` and `lk_rdy` are 0.
- R6: Logical registers 0 to 14 are user registers and 15 to 31 are privileged. With `user_mode` = 1, a lookup of a privileged register misses. With `user_mode` = 0, every newest slot can match.
- R7: `lk_data` is loaded with the slot value only on a lookup that hits a ready slot. On a miss or a not-ready hit it holds its previous value.
- R8: `alloc_ready` is 0 exactly when all 64 slots are in use. An allocate request made while it is 0 changes no mapping.
- R9: A release frees a slot, which then becomes the lowest free candidate for allocation again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_mode | input | 1 | 1 = user mode, which excludes privileged slots from the search |
| alloc_valid | input | 1 | Allocate request |
| alloc_ready | output | 1 | A free slot exists |
| alloc_lreg | input | 5 | Logical destination register |
| alloc_pidx | output | 6 | Slot that the allocation takes |
| wb_valid | input | 1 | Writeback strobe |
| wb_pidx | input | 6 | Slot being written |
| wb_data | input | 32 | Result value |
| rel_valid | input | 1 | Release strobe |
| rel_pidx | input | 6 | Slot being freed |
| lk_valid | input | 1 | Lookup strobe |
| lk_lreg | input | 5 | Logical source register |
| lk_hit | output | 1 | Lookup found a newest eligible slot |
| lk_pidx | output | 6 | Matching slot index |
| lk_rdy | output | 1 | Matching slot holds its value |
| lk_data | output | 32 | Value of the last ready hit |

## Verification
The assertions assume the following about the inputs:
- A writeback targets only a slot that is in use.
- A release names only an in-use slot that is no longer the newest mapping of its register.
- A writeback and a release never target the same slot in one cycle.

The stimulus keeps to these rules by tracking which slots it has allocated. It writes back only slots it has already received on `alloc_pidx`, and it releases only slots that a later allocation of the same register has made older.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
  localparam int CB_SLOTS = 64;
  localparam int CB_LREGS = 32;
  localparam int CB_USER  = 15;
  localparam int CB_DW    = 32;
endpackage

// File: rtl/cbuf_free_pick.sv
module cbuf_free_pick #(
  parameter int NSLOT = 64,
  localparam int PIDX_W = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0]  used_vec,
  output logic              any_free,
  output logic [PIDX_W-1:0] free_idx
);
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!used_vec[i]) begin
        any_free = 1'b1;
        free_idx = PIDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cbuf_slot_array.sv
module cbuf_slot_array #(
  parameter int NSLOT = 64,
  parameter int NLREG = 32,
  parameter int NUSER = 15,
  parameter int DW    = 32,
  localparam int PIDX_W = $clog2(NSLOT),
  localparam int LREG_W = $clog2(NLREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [PIDX_W-1:0] alloc_idx,
  input  logic [LREG_W-1:0] alloc_tag,
  input  logic              wb_valid,
  input  logic [PIDX_W-1:0] wb_idx,
  input  logic [DW-1:0]     wb_data,
  input  logic              rel_valid,
  input  logic [PIDX_W-1:0] rel_idx,
  input  logic              user_mode,
  input  logic [LREG_W-1:0] lk_tag,
  output logic [NSLOT-1:0]  used_vec,
  output logic [NSLOT-1:0]  rdy_vec,
  output logic [NSLOT-1:0]  match_vec,
  output logic [DW-1:0]     values [NSLOT]
);
  localparam logic [LREG_W-1:0] USER_LIM = LREG_W'(NUSER);

  logic [NSLOT-1:0] mr_vec;
  logic [NSLOT-1:0] priv_vec;
  logic [LREG_W-1:0] tags [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic RST_USED = (i < NLREG);
    localparam logic [LREG_W-1:0] RST_TAG = LREG_W'(i % NLREG);
    localparam logic RST_PRIV = RST_USED && (RST_TAG >= USER_LIM);

    logic take, wr, rel, older, eligible;
    assign take  = alloc_fire && (alloc_idx == PIDX_W'(i));
    assign wr    = wb_valid && (wb_idx == PIDX_W'(i));
    assign rel   = rel_valid && (rel_idx == PIDX_W'(i));
    assign older = alloc_fire && used_vec[i] && mr_vec[i] && (tags[i] == alloc_tag);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        used_vec[i] <= RST_USED;
        rdy_vec[i]  <= RST_USED;
        mr_vec[i]   <= RST_USED;
        priv_vec[i] <= RST_PRIV;
        tags[i]     <= RST_TAG;
      end else if (take) begin
        used_vec[i] <= 1'b1;
        rdy_vec[i]  <= 1'b0;
        mr_vec[i]   <= 1'b1;
        priv_vec[i] <= (alloc_tag >= USER_LIM);
        tags[i]     <= alloc_tag;
      end else begin
        if (older) mr_vec[i] <= 1'b0;
        if (wr) rdy_vec[i] <= 1'b1;
        if (rel) begin
          used_vec[i] <= 1'b0;
          mr_vec[i]   <= 1'b0;
          rdy_vec[i]  <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) values[i] <= '0;
      else if (wr) values[i] <= wb_data;
    end

    // comparator enabled only for newest, mode-eligible slots
    assign eligible     = used_vec[i] && mr_vec[i] && (!user_mode || !priv_vec[i]);
    assign match_vec[i] = eligible && (tags[i] == lk_tag);
  end

  p_alloc_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (used_vec[$past(alloc_idx)] && mr_vec[$past(alloc_idx)] && !rdy_vec[$past(alloc_idx)]));
  p_one_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
  p_wb_used_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> used_vec[wb_idx]);
  p_wb_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(rel_valid && rel_idx == wb_idx)) |=> rdy_vec[$past(wb_idx)]);
  p_user_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode |-> ((match_vec & priv_vec) == '0));
  p_rel_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (used_vec[rel_idx] && !mr_vec[rel_idx]));
endmodule

// File: rtl/cbuf_lookup.sv
module cbuf_lookup #(
  parameter int NSLOT = 64,
  parameter int DW    = 32,
  localparam int PIDX_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [NSLOT-1:0]  match_vec,
  input  logic [NSLOT-1:0]  rdy_vec,
  input  logic [DW-1:0]     values [NSLOT],
  output logic              hit_q,
  output logic [PIDX_W-1:0] idx_q,
  output logic              rdy_q,
  output logic [DW-1:0]     data_q
);
  logic              hit_c, rdy_c;
  logic [PIDX_W-1:0] idx_c;
  logic [DW-1:0]     word_c;

  always_comb begin
    hit_c  = |match_vec;
    idx_c  = '0;
    rdy_c  = 1'b0;
    word_c = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (match_vec[i]) begin
        idx_c = idx_c | PIDX_W'(i);
        rdy_c = rdy_c | rdy_vec[i];
      end
      // word line fires only for a ready match
      word_c = word_c | ({DW{match_vec[i] & rdy_vec[i]}} & values[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      idx_q  <= '0;
      rdy_q  <= 1'b0;
      data_q <= '0;
    end else if (lk_valid) begin
      hit_q <= hit_c;
      idx_q <= idx_c;
      rdy_q <= rdy_c;
      if (hit_c && rdy_c) data_q <= word_c;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && hit_c && rdy_c) |=> $stable(data_q));
  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !hit_c) |=> (!hit_q && !rdy_q && idx_q == '0));
endmodule

// File: rtl/cbuf_rename_top.sv
module cbuf_rename_top #(
  parameter int NSLOT = cbuf_pkg::CB_SLOTS,
  parameter int NLREG = cbuf_pkg::CB_LREGS,
  parameter int NUSER = cbuf_pkg::CB_USER,
  parameter int DW    = cbuf_pkg::CB_DW,
  localparam int PIDX_W = $clog2(NSLOT),
  localparam int LREG_W = $clog2(NLREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_mode,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [LREG_W-1:0] alloc_lreg,
  output logic [PIDX_W-1:0] alloc_pidx,
  input  logic              wb_valid,
  input  logic [PIDX_W-1:0] wb_pidx,
  input  logic [DW-1:0]     wb_data,
  input  logic              rel_valid,
  input  logic [PIDX_W-1:0] rel_pidx,
  input  logic              lk_valid,
  input  logic [LREG_W-1:0] lk_lreg,
  output logic              lk_hit,
  output logic [PIDX_W-1:0] lk_pidx,
  output logic              lk_rdy,
  output logic [DW-1:0]     lk_data
);
  logic [NSLOT-1:0] used_vec, rdy_vec, match_vec;
  logic [DW-1:0]    values [NSLOT];
  logic             alloc_fire;

  cbuf_free_pick #(.NSLOT(NSLOT)) u_pick (
    .used_vec(used_vec), .any_free(alloc_ready), .free_idx(alloc_pidx)
  );

  assign alloc_fire = alloc_valid && alloc_ready;

  cbuf_slot_array #(.NSLOT(NSLOT), .NLREG(NLREG), .NUSER(NUSER), .DW(DW)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .alloc_idx(alloc_pidx), .alloc_tag(alloc_lreg),
    .wb_valid(wb_valid), .wb_idx(wb_pidx), .wb_data(wb_data),
    .rel_valid(rel_valid), .rel_idx(rel_pidx),
    .user_mode(user_mode), .lk_tag(lk_lreg),
    .used_vec(used_vec), .rdy_vec(rdy_vec), .match_vec(match_vec), .values(values)
  );

  cbuf_lookup #(.NSLOT(NSLOT), .DW(DW)) u_look (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
    .match_vec(match_vec), .rdy_vec(rdy_vec), .values(values),
    .hit_q(lk_hit), .idx_q(lk_pidx), .rdy_q(lk_rdy), .data_q(lk_data)
  );

  p_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_ready |-> (&used_vec));
  p_free_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ready |-> !used_vec[alloc_pidx]);
endmodule

// File: tb/cbuf_rename_top_tb.sv
module cbuf_rename_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic user_mode = 1'b0;
  logic alloc_valid = 1'b0;
  logic alloc_ready;
  logic [4:0] alloc_lreg = '0;
  logic [5:0] alloc_pidx;
  logic wb_valid = 1'b0;
  logic [5:0] wb_pidx = '0;
  logic [31:0] wb_data = '0;
  logic rel_valid = 1'b0;
  logic [5:0] rel_pidx = '0;
  logic lk_valid = 1'b0;
  logic [4:0] lk_lreg = '0;
  logic lk_hit, lk_rdy;
  logic [5:0] lk_pidx;
  logic [31:0] lk_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cbuf_rename_top u_dut (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_lreg(alloc_lreg), .alloc_pidx(alloc_pidx),
    .wb_valid(wb_valid), .wb_pidx(wb_pidx), .wb_data(wb_data),
    .rel_valid(rel_valid), .rel_pidx(rel_pidx),
    .lk_valid(lk_valid), .lk_lreg(lk_lreg),
    .lk_hit(lk_hit), .lk_pidx(lk_pidx), .lk_rdy(lk_rdy), .lk_data(lk_data)
  );

  typedef enum logic [1:0] {OP_ALLOC, OP_WB, OP_LOOK, OP_REL} op_e;
  typedef struct packed {
    op_e         op;
    logic [4:0]  lreg;
    logic        usr;
    logic [5:0]  pidx;
    logic [31:0] dat;
    logic        hit;
    logic        rdy;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VEC [NVEC] = '{
    '{OP_LOOK,  5'd3,  1'b0, 6'd3,  32'h0,         1'b1, 1'b1},
    '{OP_ALLOC, 5'd3,  1'b0, 6'd32, 32'h0,         1'b0, 1'b0},
    '{OP_LOOK,  5'd3,  1'b0, 6'd32, 32'h0,         1'b1, 1'b0},
    '{OP_WB,    5'd0,  1'b0, 6'd32, 32'hAAAA_0003, 1'b0, 1'b0},
    '{OP_LOOK,  5'd3,  1'b0, 6'd32, 32'hAAAA_0003, 1'b1, 1'b1},
    '{OP_ALLOC, 5'd20, 1'b0, 6'd33, 32'h0,         1'b0, 1'b0},
    '{OP_ALLOC, 5'd3,  1'b0, 6'd34, 32'h0,         1'b0, 1'b0},
    '{OP_WB,    5'd0,  1'b0, 6'd34, 32'h0000_3434, 1'b0, 1'b0},
    '{OP_LOOK,  5'd20, 1'b0, 6'd33, 32'hAAAA_0003, 1'b1, 1'b0},
    '{OP_LOOK,  5'd20, 1'b1, 6'd0,  32'hAAAA_0003, 1'b0, 1'b0},
    '{OP_LOOK,  5'd3,  1'b1, 6'd34, 32'h0000_3434, 1'b1, 1'b1},
    '{OP_WB,    5'd0,  1'b0, 6'd33, 32'h0000_2020, 1'b0, 1'b0},
    '{OP_LOOK,  5'd20, 1'b0, 6'd33, 32'h0000_2020, 1'b1, 1'b1},
    '{OP_REL,   5'd0,  1'b0, 6'd32, 32'h0,         1'b0, 1'b0},
    '{OP_ALLOC, 5'd7,  1'b0, 6'd32, 32'h0,         1'b0, 1'b0},
    '{OP_LOOK,  5'd7,  1'b1, 6'd32, 32'h0000_2020, 1'b1, 1'b0},
    '{OP_LOOK,  5'd14, 1'b1, 6'd14, 32'h0,         1'b1, 1'b1},
    '{OP_LOOK,  5'd15, 1'b1, 6'd0,  32'h0,         1'b0, 1'b0},
    '{OP_LOOK,  5'd15, 1'b0, 6'd15, 32'h0,         1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [4:0] t, input logic [5:0] e, input string tag);
    alloc_valid = 1'b1; alloc_lreg = t;
    #1;
    chk(tag, 32'(alloc_ready), 32'd1);
    chk(tag, 32'(alloc_pidx), 32'(e));
    @(posedge clk); @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic do_wb(input logic [5:0] p, input logic [31:0] d);
    wb_valid = 1'b1; wb_pidx = p; wb_data = d;
    @(posedge clk); @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic do_rel(input logic [5:0] p);
    rel_valid = 1'b1; rel_pidx = p;
    @(posedge clk); @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic do_look(input logic [4:0] t, input logic u, input logic eh,
                         input logic [5:0] ep, input logic er, input logic [31:0] ed,
                         input string tag);
    lk_valid = 1'b1; lk_lreg = t; user_mode = u;
    @(posedge clk); @(negedge clk);
    lk_valid = 1'b0;
    #1;
    chk(tag, 32'(lk_hit), 32'(eh));
    chk(tag, 32'(lk_pidx), 32'(ep));
    chk(tag, 32'(lk_rdy), 32'(er));
    chk(tag, lk_data, ed);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state at the ports
    chk("R1", 32'(alloc_ready), 32'd1);
    chk("R1", 32'(alloc_pidx), 32'd32);
    chk("R1", 32'(lk_hit), 32'd0);
    chk("R1", lk_data, 32'd0);
    @(negedge clk);

    // vector table: R2 R3 R4 R5 R6 R7 R9
    for (int k = 0; k < NVEC; k++) begin
      case (VEC[k].op)
        OP_ALLOC: do_alloc(VEC[k].lreg, VEC[k].pidx, "R2");
        OP_WB:    do_wb(VEC[k].pidx, VEC[k].dat);
        OP_REL:   do_rel(VEC[k].pidx);
        default:  do_look(VEC[k].lreg, VEC[k].usr, VEC[k].hit, VEC[k].pidx,
                          VEC[k].rdy, VEC[k].dat, "R3_R5_R6_R7");
      endcase
    end

    // R1: another reset-image register, privileged mode
    do_look(5'd31, 1'b0, 1'b1, 6'd31, 1'b1, 32'h0, "R1");

    // R8: fill the remaining free slots 35..63
    for (int k = 0; k < 29; k++) do_alloc(5'd9, 6'(35 + k), "R8");
    #1;
    chk("R8", 32'(alloc_ready), 32'd0);
    alloc_valid = 1'b1; alloc_lreg = 5'd2;
    @(posedge clk); @(negedge clk);
    alloc_valid = 1'b0;
    do_look(5'd2, 1'b0, 1'b1, 6'd2, 1'b1, 32'h0, "R8");
    do_look(5'd9, 1'b1, 1'b1, 6'd63, 1'b0, 32'h0, "R3");

    // R9: release an older mapping, then reuse it
    do_rel(6'd40);
    #1;
    chk("R9", 32'(alloc_ready), 32'd1);
    do_alloc(5'd10, 6'd40, "R9");
    do_look(5'd10, 1'b1, 1'b1, 6'd40, 1'b0, 32'h0, "R9");
    do_wb(6'd40, 32'hDEAD_BEEF);
    do_look(5'd10, 1'b1, 1'b1, 6'd40, 1'b1, 32'hDEAD_BEEF, "R4");
    // R7: a miss after a ready hit keeps the data
    do_look(5'd25, 1'b1, 1'b0, 6'd0, 1'b0, 32'hDEAD_BEEF, "R7");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule